// File: doc/BRIEF.md
# Constant Off-Time Current Chopper

This block regulates the current in one H-bridge winding with a fixed off period. While the bridge is on, a synchronised comparator level reports when the sensed coil current has gone above its reference. When that happens the block switches the bridge off and holds it off for a programmed number of clock cycles plus a fixed dead-time allowance. It then switches the bridge back on. The switching period therefore follows the load, and the off time stays constant.

Every turn-on opens a blanking window. During that window the comparator is not looked at, so the current spike from diode recovery cannot end the on phase early. A minimum on time is also kept. A comparator trip that arrives after blanking but before the minimum has elapsed is held, and it takes effect once the minimum is reached. A single-cycle marker flags the first cycle of every off phase, so the gate logic can apply its decay action there. Dropping the enable forces the bridge off and clears every timer. Raising it again starts a fresh on phase with blanking.

Top module: `offtime_chopper`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bridgeOn` and `offStart` are both 0.
- R2: When `enable` is sampled high at a clock edge after a cycle in which it was low, `bridgeOn` is 1 from that edge on.
- R3: In the first BLANK_CYC cycles of each on phase, `overThresh` has no effect. A pulse in that window does not end the on phase.
- R4: After blanking and once at least MIN_ON_CYC on-cycles are complete, `overThresh` sampled high at the edge that ends on-cycle k (counting from 0) drives `bridgeOn` low at that edge. The on phase is then k+1 cycles long.
- R5: An on phase lasts at least MIN_ON_CYC cycles. A single-cycle trip seen after blanking but before the minimum is held, and it ends the on phase after exactly MIN_ON_CYC cycles.
- R6: An off phase keeps `bridgeOn` low for exactly the captured off value plus DEAD_CYC cycles. `bridgeOn` then returns high.
- R7: A value of 0 written through `offWr`/`offIn` is stored as 1.
- R8: `overThresh` has no effect while the bridge is off. The off-phase length does not depend on it.
- R9: `offStart` is 1 for exactly one cycle: the first cycle in which `bridgeOn` is low after an on phase. At all other times it is 0.
- R10: `enable` sampled low at an edge makes `bridgeOn` and `offStart` 0 from that edge on. After re-enable, the new on phase has full blanking and a full minimum on time.
- R11: The off value is captured when an off phase starts. A write during an off phase affects only later off phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Bridge enable; low forces off and clears the timers |
| overThresh | input | 1 | Synchronised comparator: sensed current above the reference |
| offWr | input | 1 | Write strobe for the off-time value |
| offIn | input | OFF_W | Off time in clock cycles (0 is stored as 1) |
| bridgeOn | output | 1 | Phase flag to the gate logic: 1 = conducting, 0 = off phase |
| offStart | output | 1 | One-cycle marker for the first cycle of an off phase |

## Verification
The assertions assume that `overThresh`, `enable` and the write port are synchronous levels that change only between clock edges. They also assume that `offIn` is within the OFF_W range. The bench drives every input on the falling edge so that it stays within these assumptions. The bench sweeps every off value of a 4-bit configuration against every trip position in the first eight on-cycles, using both held and single-cycle comparator patterns. The comparator is held high throughout each off phase, so any leak of it into the off timer would show up as a wrong length. Directed runs cover enable removal in both phases and a rewrite of the off value while an off phase is running.

// File: rtl/offtime_chopper_pkg.sv
package offtime_chopper_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ON   = 2'd1,
    ST_OFF  = 2'd2
  } chopState_t;

  // Strobes from the control FSM to the timer datapath
  typedef struct packed {
    logic clrOn;     // restart the on-phase counter
    logic incOn;     // advance the on-phase counter
    logic startOff;  // capture off value, restart off counter
    logic incOff;    // advance the off-phase counter
    logic clrOff;    // clear the off counter
  } chopStrobes_t;

endpackage

// File: rtl/chop_datapath.sv
module chop_datapath
  import offtime_chopper_pkg::*;
#(
  parameter int OFF_W      = 20,
  parameter int BLANK_CYC  = 125,
  parameter int MIN_ON_CYC = 188,
  parameter int DEAD_CYC   = 125,
  parameter int OFF_RESET  = 825
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chopStrobes_t     stb,
  input  logic             offWr,
  input  logic [OFF_W-1:0] offIn,
  output logic             blankDone,
  output logic             minOnDone,
  output logic             offDone
);

  localparam int ON_MAX = (BLANK_CYC > MIN_ON_CYC) ? BLANK_CYC : MIN_ON_CYC;
  localparam int ON_W   = $clog2(ON_MAX + 1);
  localparam int LEN_W  = OFF_W + $clog2(DEAD_CYC + 2) + 1;

  localparam logic [ON_W-1:0]  ON_SAT   = ON_W'(ON_MAX);
  localparam logic [ON_W-1:0]  BLANK_V  = ON_W'(BLANK_CYC);
  localparam logic [ON_W-1:0]  MIN_LAST = ON_W'(MIN_ON_CYC - 1);
  localparam logic [LEN_W-1:0] DEAD_V   = LEN_W'(DEAD_CYC);
  localparam logic [OFF_W-1:0] RST_V    = (OFF_RESET == 0) ? OFF_W'(1) : OFF_W'(OFF_RESET);

  logic [ON_W-1:0]  onCnt;
  logic [OFF_W-1:0] offReg;
  logic [OFF_W-1:0] offTarget;
  logic [LEN_W-1:0] offCnt;
  logic [LEN_W-1:0] offLen;

  // Programmed off time, zero clamped to one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offReg <= RST_V;
    end else if (offWr) begin
      offReg <= (offIn == '0) ? OFF_W'(1) : offIn;
    end
  end

  // On-phase counter, saturates once both windows have elapsed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      onCnt <= '0;
    end else if (stb.clrOn) begin
      onCnt <= '0;
    end else if (stb.incOn && onCnt != ON_SAT) begin
      onCnt <= onCnt + ON_W'(1);
    end
  end

  // Off-phase counter and captured length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offCnt    <= '0;
      offTarget <= RST_V;
    end else if (stb.startOff) begin
      offCnt    <= '0;
      offTarget <= offReg;
    end else if (stb.clrOff) begin
      offCnt    <= '0;
    end else if (stb.incOff) begin
      offCnt    <= offCnt + LEN_W'(1);
    end
  end

  assign offLen    = LEN_W'(offTarget) + DEAD_V;
  assign blankDone = (onCnt >= BLANK_V);
  assign minOnDone = (onCnt >= MIN_LAST);
  assign offDone   = ((offCnt + LEN_W'(1)) == offLen);

endmodule

// File: rtl/chop_control.sv
module chop_control
  import offtime_chopper_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         overThresh,
  input  logic         blankDone,
  input  logic         minOnDone,
  input  logic         offDone,
  output chopStrobes_t stb,
  output logic         bridgeOn,
  output logic         offStart
);

  chopState_t state;
  chopState_t nextState;
  logic       tripPend;
  logic       tripNow;
  logic       turnOff;

  assign tripNow = overThresh && blankDone;
  assign turnOff = (state == ST_ON) && (tripNow || tripPend) && minOnDone;

  always_comb begin
    stb       = '0;
    nextState = state;
    if (!enable) begin
      nextState  = ST_IDLE;
      stb.clrOn  = 1'b1;
      stb.clrOff = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          nextState = ST_ON;
          stb.clrOn = 1'b1;
        end
        ST_ON: begin
          if (turnOff) begin
            nextState    = ST_OFF;
            stb.startOff = 1'b1;
            stb.clrOn    = 1'b1;
          end else begin
            stb.incOn = 1'b1;
          end
        end
        ST_OFF: begin
          if (offDone) begin
            nextState = ST_ON;
            stb.clrOn = 1'b1;
          end else begin
            stb.incOff = 1'b1;
          end
        end
        default: begin
          nextState = ST_IDLE;
          stb.clrOn = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bridgeOn <= 1'b0;
      offStart <= 1'b0;
      tripPend <= 1'b0;
    end else begin
      state    <= nextState;
      bridgeOn <= (nextState == ST_ON);
      offStart <= enable && turnOff;
      if (enable && state == ST_ON && !turnOff) begin
        tripPend <= tripPend || tripNow;
      end else begin
        tripPend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper
  import offtime_chopper_pkg::*;
#(
  parameter int OFF_W      = 20,
  parameter int BLANK_CYC  = 125,
  parameter int MIN_ON_CYC = 188,
  parameter int DEAD_CYC   = 125,
  parameter int OFF_RESET  = 825
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             overThresh,
  input  logic             offWr,
  input  logic [OFF_W-1:0] offIn,
  output logic             bridgeOn,
  output logic             offStart
);

  chopStrobes_t stb;
  logic         blankDone;
  logic         minOnDone;
  logic         offDone;

  chop_control u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .overThresh (overThresh),
    .blankDone  (blankDone),
    .minOnDone  (minOnDone),
    .offDone    (offDone),
    .stb        (stb),
    .bridgeOn   (bridgeOn),
    .offStart   (offStart)
  );

  chop_datapath #(
    .OFF_W      (OFF_W),
    .BLANK_CYC  (BLANK_CYC),
    .MIN_ON_CYC (MIN_ON_CYC),
    .DEAD_CYC   (DEAD_CYC),
    .OFF_RESET  (OFF_RESET)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .offWr     (offWr),
    .offIn     (offIn),
    .blankDone (blankDone),
    .minOnDone (minOnDone),
    .offDone   (offDone)
  );

endmodule

// File: rtl/offtime_chopper_chk.sv
module offtime_chopper_chk #(
  parameter int MIN_ON_CYC = 188
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic bridgeOn,
  input logic offStart
);

  logic [15:0] onRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      onRun <= '0;
    end else if (bridgeOn) begin
      if (onRun != 16'hFFFF) onRun <= onRun + 16'd1;
    end else begin
      onRun <= '0;
    end
  end

  // R9
  offstart_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offStart |-> (!bridgeOn && $past(bridgeOn)));

  // R9
  offstart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offStart |=> !offStart);

  // R10
  enable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!bridgeOn && !offStart));

  // R2
  enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |=> bridgeOn);

  // R5
  min_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offStart |-> (32'(onRun) >= MIN_ON_CYC));

endmodule

bind offtime_chopper offtime_chopper_chk #(.MIN_ON_CYC(MIN_ON_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .bridgeOn (bridgeOn),
  .offStart (offStart)
);

// File: tb/offtime_chopper_bench.sv
module offtime_chopper_bench;

  localparam int OFF_W  = 4;
  localparam int BLANK  = 3;
  localparam int MIN_ON = 5;
  localparam int DEAD   = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic             overThresh = 1'b0;
  logic             offWr = 1'b0;
  logic [OFF_W-1:0] offIn = '0;
  logic             bridgeOn;
  logic             offStart;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  offtime_chopper #(
    .OFF_W(OFF_W), .BLANK_CYC(BLANK), .MIN_ON_CYC(MIN_ON),
    .DEAD_CYC(DEAD), .OFF_RESET(3)
  ) u_offtime_chopper (
    .clk(clk), .rst_n(rst_n), .enable(enable), .overThresh(overThresh),
    .offWr(offWr), .offIn(offIn), .bridgeOn(bridgeOn), .offStart(offStart)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expOn(int t, bit pulse);
    int k;
    k = (pulse && t < BLANK) ? 9 : t;
    if (k < BLANK) k = BLANK;
    if (k < MIN_ON - 1) k = MIN_ON - 1;
    return k + 1;
  endfunction

  function automatic string onTag(int t, bit pulse);
    if (t < BLANK) return "R3";
    if (t < MIN_ON - 1) return pulse ? "R5" : "R5 held";
    return "R4";
  endfunction

  task automatic writeOff(int v);
    offWr = 1'b1;
    offIn = OFF_W'(v);
    @(negedge clk);
    offWr = 1'b0;
  endtask

  // Measure one on phase with a given comparator pattern, then one off phase
  task automatic runOne(int t, bit pulse, int ld);
    int onLen;
    int offLen;
    @(negedge clk);
    enable = 1'b0;
    overThresh = 1'b0;
    writeOff(ld);
    check(bridgeOn == 1'b0, "R10 disabled", int'(bridgeOn), 0);
    enable = 1'b1;
    @(negedge clk);
    check(bridgeOn == 1'b1, "R2 turn-on", int'(bridgeOn), 1);
    onLen = 0;
    while (bridgeOn && onLen < 40) begin
      overThresh = pulse ? (onLen == t || onLen >= 9) : (onLen >= t);
      onLen++;
      @(negedge clk);
    end
    check(onLen == expOn(t, pulse), onTag(t, pulse), onLen, expOn(t, pulse));
    check(offStart == 1'b1, "R9 first off cycle", int'(offStart), 1);
    overThresh = 1'b1;  // R8: comparator high for the whole off phase
    offLen = 0;
    while (!bridgeOn && offLen < 60) begin
      offLen++;
      @(negedge clk);
      if (offLen == 1 && !bridgeOn)
        check(offStart == 1'b0, "R9 single cycle", int'(offStart), 0);
    end
    check(offLen == ((ld == 0) ? 1 : ld) + DEAD, (ld == 0) ? "R7" : "R6 R8",
          offLen, ((ld == 0) ? 1 : ld) + DEAD);
    enable = 1'b0;
    overThresh = 1'b0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(bridgeOn == 1'b0 && offStart == 1'b0, "R1 in reset",
          int'({bridgeOn, offStart}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bridgeOn == 1'b0 && offStart == 1'b0, "R1 after reset",
          int'({bridgeOn, offStart}), 0);

    for (int ld = 0; ld < 16; ld++)
      for (int t = 0; t < 8; t++)
        for (int p = 0; p < 2; p++)
          runOne(t, p[0], ld);

    // R10: enable dropped during an on phase
    @(negedge clk);
    writeOff(6);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(bridgeOn == 1'b0 && offStart == 1'b0, "R10 abort on",
          int'({bridgeOn, offStart}), 0);

    // R10: enable dropped during an off phase, re-enable gets fresh blanking
    enable = 1'b1;
    overThresh = 1'b1;
    @(negedge clk);
    n = 0;
    while (bridgeOn && n < 40) begin n++; @(negedge clk); end
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(bridgeOn == 1'b0 && offStart == 1'b0, "R10 abort off",
          int'({bridgeOn, offStart}), 0);
    enable = 1'b1;
    @(negedge clk);
    check(bridgeOn == 1'b1, "R10 restart", int'(bridgeOn), 1);
    n = 0;
    while (bridgeOn && n < 40) begin n++; @(negedge clk); end
    check(n == MIN_ON, "R10 fresh blanking", n, MIN_ON);

    // R11: write during an off phase affects only the next one
    enable = 1'b0;
    overThresh = 1'b0;
    @(negedge clk);
    writeOff(2);
    enable = 1'b1;
    overThresh = 1'b1;
    @(negedge clk);
    n = 0;
    while (bridgeOn && n < 40) begin n++; @(negedge clk); end
    writeOff(9);
    n = 1;
    while (!bridgeOn && n < 60) begin n++; @(negedge clk); end
    check(n == 2 + DEAD, "R11 current off", n, 2 + DEAD);
    while (bridgeOn && n < 200) begin n++; @(negedge clk); end
    n = 0;
    while (!bridgeOn && n < 60) begin n++; @(negedge clk); end
    check(n == 9 + DEAD, "R11 next off", n, 9 + DEAD);

    enable = 1'b0;
    overThresh = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule